// File: doc/BRIEF.md
# Radix-4 Recoded Signed Array Multiplier

This block multiplies two N-bit two's complement integers and delivers the 2N-bit two's complement product. The multiplier operand is scanned in overlapping groups of three bits. Each group becomes one signed radix-4 digit in the range -2 to +2, so N/2 partial-product rows replace the N rows of a bit-serial scheme. Each row is the multiplicand, doubled, inverted or cleared according to its digit. A negative row adds its +1 as a lone bit in the empty low slot of the following row. The +1 of the top row goes into an extra operand.

Sign extension of the rows is not built. The top bit of each row is complemented, and one precomputed constant absorbs the dropped extension for all rows together. The operands are folded to two vectors by a linear chain of 3:2 carry-save stages, and one carry-propagate addition finishes the product. A parameter selects a single output register (the default) or a purely combinational output. N must be even and at least 4.

Top module: `radix4_smul`

## Requirements
- R1: With the output register enabled, `prod_o` holds the exact two's complement product of `mcand_i` and `mplier_i` as a 2N-bit vector, for every operand pair.
- R2: The product of the operands present at a rising clock edge appears at `prod_o` after that edge and not before it, which is a latency of exactly one cycle.
- R3: While `rst_n` is low, `prod_o` is all zeros whatever the operands are.
- R4: When either operand is zero, the product is zero.
- R5: Bit 2N-1 of the product is set exactly when both operands are nonzero and their sign bits differ.
- R6: When both operands are the most negative value -2^(N-1), the product is +2^(2N-2), with only bit 2N-2 set. No other operand pair produces this value.
- R7: Multiplier bits are recoded in groups (y[2j+1], y[2j], y[2j-1]), where y[-1] = 0. The groups map as 000 to 0, 001 to +1, 010 to +1, 011 to +2, 100 to -2, 101 to -1, 110 to -1 and 111 to 0. The multiplier 01011110 therefore gives digits (+1,+2,0,-2), most significant first, and 10001101 gives (-2,+1,-1,+1). The products for both multipliers must be exact.
- R8: A group 111, which is a negative zero digit, contributes nothing. A multiplier of all ones (-1) therefore returns the negated multiplicand.
- R9: A multiplicand of -2^(N-1) multiplied by digits of magnitude two gives an exact product. Doubling it needs one more bit than the operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, clears the output register |
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement, recoded in radix 4 |
| prod_o | output | 2N | Product, two's complement |

## Verification
The block has no internal state apart from the output register, so a fault in the recoding, row forming or compression shows up at `prod_o` one cycle after the operands that expose it. A wrong entry in the group mapping spoils every multiplier that contains that group. A misplaced carry bit or a wrong sign constant shifts the product by a fixed power of two, and only for some sign patterns. For that reason all operand pairs at the default width are applied, and each product is checked on the cycle after its operands.

// File: rtl/radix4_smul_pkg.sv
package radix4_smul_pkg;

  // Control for one partial-product row, decoded from a multiplier bit group.
  typedef struct packed {
    logic neg;   // invert the selected multiple and add one
    logic one;   // select the multiplicand
    logic two;   // select twice the multiplicand
  } digit_sel_t;

endpackage

// File: rtl/r4_digit_decode.sv
module r4_digit_decode
  import radix4_smul_pkg::*;
(
  input  logic [2:0]  grp_i,   // {y[2j+1], y[2j], y[2j-1]}
  output digit_sel_t  sel_o
);

  always_comb begin
    sel_o.neg = grp_i[2];
    sel_o.one = grp_i[1] ^ grp_i[0];
    sel_o.two = (~grp_i[2] & grp_i[1] & grp_i[0]) |
                (grp_i[2] & ~grp_i[1] & ~grp_i[0]);
  end

  // R7: a digit has magnitude one or two, never both
  always_comb begin
    assert_sel_exclusive_R7: assert (!(sel_o.one && sel_o.two));
  end

endmodule

// File: rtl/r4_row_form.sv
module r4_row_form
  import radix4_smul_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 2 * N,
  parameter int POS = 0          // row index; the row starts at column 2*POS
)(
  input  logic [N-1:0] mcand_i,
  input  digit_sel_t   sel_i,
  output logic [W-1:0] row_o,
  output logic         cy_o       // +1 owed by a negative row
);

  localparam int MW  = N + 1;
  localparam int LSB = 2 * POS;

  logic [MW-1:0] mult;
  logic [MW-1:0] mult_x;

  always_comb begin
    if (sel_i.two)      mult = {mcand_i, 1'b0};
    else if (sel_i.one) mult = {mcand_i[N-1], mcand_i};
    else                mult = '0;
    mult_x = mult ^ {MW{sel_i.neg}};
  end

  always_comb begin
    row_o = '0;
    row_o[LSB +: MW] = {~mult_x[MW-1], mult_x[MW-2:0]};
    cy_o  = sel_i.neg;
  end

endmodule

// File: rtl/csa_fold_chain.sv
module csa_fold_chain #(
  parameter int W = 16,
  parameter int K = 5            // operand count, at least 3
)(
  input  logic [W-1:0] ops_i [K],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] car_o
);

  localparam int STG = K - 1;

  logic [W-1:0] s_v [STG];
  logic [W-1:0] c_v [STG];

  assign s_v[0] = ops_i[0];
  assign c_v[0] = ops_i[1];

  for (genvar k = 1; k < STG; k++) begin : g_stage
    logic [W-1:0] maj;
    assign s_v[k] = s_v[k-1] ^ c_v[k-1] ^ ops_i[k+1];
    assign maj    = (s_v[k-1] & c_v[k-1]) | (s_v[k-1] & ops_i[k+1]) |
                    (c_v[k-1] & ops_i[k+1]);
    assign c_v[k] = {maj[W-2:0], 1'b0};
  end

  assign sum_o = s_v[STG-1];
  assign car_o = c_v[STG-1];

endmodule

// File: rtl/radix4_smul.sv
module radix4_smul
  import radix4_smul_pkg::*;
#(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     mcand_i,
  input  logic [N-1:0]     mplier_i,
  output logic [2*N-1:0]   prod_o
);

  localparam int W  = 2 * N;
  localparam int M  = N / 2;      // digit count
  localparam int K  = M + 1;      // rows plus the constant/carry operand

  // Fixed pattern that stands in for the dropped sign extension of every row.
  function automatic logic [W-1:0] sign_fix();
    logic [W-1:0] acc;
    acc = '0;
    for (int j = 0; j < M; j++)
      acc = acc - ({{(W-1){1'b0}}, 1'b1} << (N + 2 * j));
    return acc;
  endfunction

  localparam logic [W-1:0] SIGN_FIX = sign_fix();

  logic [N:0]   y_ext;
  digit_sel_t   sel   [M];
  logic [W-1:0] row   [M];
  logic [M-1:0] cy;
  logic [W-1:0] ops   [K];
  logic [W-1:0] fold_s;
  logic [W-1:0] fold_c;
  logic [W-1:0] prod_d;

  assign y_ext = {mplier_i, 1'b0};

  for (genvar j = 0; j < M; j++) begin : g_row
    r4_digit_decode u_dec (
      .grp_i (y_ext[2*j +: 3]),
      .sel_o (sel[j])
    );
    r4_row_form #(.N(N), .W(W), .POS(j)) u_row (
      .mcand_i (mcand_i),
      .sel_i   (sel[j]),
      .row_o   (row[j]),
      .cy_o    (cy[j])
    );
    if (j == 0) begin : g_first
      assign ops[0] = row[0];
    end else begin : g_rest
      // the previous row's +1 fills the free low slot of this row
      assign ops[j] = row[j] | ({{(W-1){1'b0}}, cy[j-1]} << (2 * j - 2));
    end
  end

  assign ops[M] = SIGN_FIX | ({{(W-1){1'b0}}, cy[M-1]} << (2 * M - 2));

  csa_fold_chain #(.W(W), .K(K)) u_fold (
    .ops_i (ops),
    .sum_o (fold_s),
    .car_o (fold_c)
  );

  always_comb begin
    prod_d = fold_s + fold_c;
  end

  if (OUT_REG) begin : g_reg
    localparam logic [N-1:0] MIN_IN  = {1'b1, {(N-1){1'b0}}};
    localparam logic [W-1:0] MAX_OUT = {2'b01, {(W-2){1'b0}}};

    logic [W-1:0] prod_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_d;
    end

    assign prod_o = prod_q;

    assert_zero_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(mcand_i) == '0 || $past(mplier_i) == '0))
      |-> (prod_o == '0));

    assert_sign_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(mcand_i) != '0 && $past(mplier_i) != '0)
      |-> (prod_o[W-1] == ($past(mcand_i[N-1]) ^ $past(mplier_i[N-1]))));

    assert_peak_only_min_sq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_o == MAX_OUT)
      |-> ($past(mcand_i) == MIN_IN && $past(mplier_i) == MIN_IN));
  end else begin : g_comb
    assign prod_o = prod_d;
  end

endmodule

// File: tb/radix4_smul_test.sv
`timescale 1ns/1ps
module radix4_smul_test;

  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] a;
  logic [N-1:0] b;
  logic [W-1:0] prod;

  int    n_checks;
  int    n_fail;
  bit    have_prev;
  int    exp_prev;
  string tag_prev;

  radix4_smul #(.N(N), .OUT_REG(1'b1)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mcand_i  (a),
    .mplier_i (b),
    .prod_o   (prod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (a=%0d b=%0d)", req, act, exp,
               $signed(a), $signed(b));
    end
  endtask

  function automatic string pick_tag(input logic [N-1:0] x, input logic [N-1:0] y);
    if (x == 0 || y == 0)                    return "R4";
    if (x == 8'h80 && y == 8'h80)            return "R6";
    if (y == 8'hFF)                          return "R8";
    if (x == 8'h80)                          return "R9";
    if (y == 8'h5E || y == 8'h8D)            return "R7";
    return "R1";
  endfunction

  // Compares the product of the previous operands, then applies new ones.
  task automatic step(input logic [N-1:0] x, input logic [N-1:0] y, input bit lat_chk);
    @(negedge clk);
    if (have_prev) begin
      check(tag_prev, int'($signed(prod)), exp_prev);
      check("R5", int'(prod[W-1]), int'(exp_prev < 0));
    end
    a = x;
    b = y;
    if (lat_chk && have_prev) begin
      #1;
      // R2: new operands must not reach the output before the next edge
      check("R2", int'($signed(prod)), exp_prev);
    end
    exp_prev  = int'($signed(x)) * int'($signed(y));
    tag_prev  = pick_tag(x, y);
    have_prev = 1'b1;
  endtask

  bit done;

  initial begin
    n_checks  = 0;
    n_fail    = 0;
    have_prev = 1'b0;
    done      = 1'b0;
    rst_n     = 1'b0;
    a         = 8'd5;
    b         = 8'd7;
    repeat (3) @(negedge clk);
    check("R3", int'(prod), 0);
    a = 8'h81;
    b = 8'h80;
    @(negedge clk);
    check("R3", int'(prod), 0);
    rst_n = 1'b1;

    step(8'd3,   8'h5E, 1'b1);   // R7 example 94
    step(8'hF9,  8'h8D, 1'b1);   // R7 example -115
    step(8'h80,  8'h80, 1'b1);   // R6
    step(8'h7F,  8'h80, 1'b1);   // R6 neighbour
    step(8'h80,  8'd2,  1'b1);   // R9
    step(8'h80,  8'hFE, 1'b1);   // R9
    step(8'd37,  8'hFF, 1'b1);   // R8
    step(8'h00,  8'h99, 1'b1);   // R4
    step(8'h7F,  8'h7F, 1'b1);   // R1

    for (int i = 0; i < 256; i++) begin
      for (int k = 0; k < 256; k++) begin
        step(i[N-1:0], k[N-1:0], 1'b0);
      end
    end
    @(negedge clk);
    check(tag_prev, int'($signed(prod)), exp_prev);
    check("R5", int'(prod[W-1]), int'(exp_prev < 0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule